// File: doc/BRIEF.md
# Chained Descriptor Loader for a Scatter-Gather DMA Channel

This block sequences one DMA channel through a list of transfer segments. Software either writes the segment registers directly or lets the block pull them from memory. The segment registers are the link, byte count, source, destination and configuration. A write to the configuration register with its enable bit set starts the channel. The block then hands the loaded segment to the transfer engine with a one-cycle launch pulse and waits for that engine to report the segment done.

When a segment finishes, the block looks at the link word. If the link word's chaining flag is set, the block reads the next 32-byte descriptor from memory, one word at a time, through a request/acknowledge read port. It loads the registers from that descriptor and launches the next segment. If the flag is clear, the chain is over. The block then raises a single transfer-complete pulse and drops the enable bit.

While a segment runs, the engine reports the bytes it has moved. The block subtracts them from the count register, so software can read the current link and the remaining count to work out the residue. If a descriptor read returns an error, the block raises an error pulse and halts until software writes the configuration register again.

Top module: `desc_seq`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `rd_req`, `seg_start`, `tc_event` and `err_event` are 0 and all five segment registers read 0.
- R2: While the channel is not busy, a write with `sw_wr_en` high stores `sw_wr_data` in the register selected by `sw_wr_sel`: 0 is the link, 1 the count, 2 the source, 3 the destination and 4 the configuration. The stored value appears on the matching `cur_*` output from the next cycle.
- R3: A configuration write with bit 0 (enable) set, made while the channel is idle or halted, makes `seg_start` high for exactly one cycle and makes `busy` rise.
- R4: Software writes made while `busy` is high change none of the segment registers.
- R5: When a segment finishes and bit 1 of the link register is set, the block reads 8 words. The first word is at the link value with its low 5 bits cleared, and each following word is 4 bytes higher. Only one request is outstanding at a time, and `rd_req` and `rd_addr` are held until `rd_ack`.
- R6: From a fetched descriptor, word 0 goes to the link, word 4 to the count, word 5 to the source, word 6 to the destination and word 7 to the configuration. Words 1 to 3 are discarded. The next segment is then launched with a `seg_start` pulse.
- R7: When a segment finishes and bit 1 of the link register is clear (this includes a zero link), no descriptor is read. `tc_event` pulses once, `busy` falls and bit 0 of the configuration register is cleared. There is no `tc_event` between the segments of a chain.
- R8: The count register never holds more than MAX_SEG (0x1ffc). A larger value, whether written by software or fetched from memory, is stored as MAX_SEG.
- R9: While a segment runs, each `seg_xfer_vld` cycle subtracts `seg_xfer_bytes` from the count register, stopping at 0. The link register stays readable throughout.
- R10: A read acknowledged with `rd_err` high makes `err_event` pulse for one cycle. The block then drops `busy` and clears bit 0 of the configuration register, with no `seg_start` and no `tc_event`. A later enabling configuration write restarts the channel from its registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_wr_sel | input | 3 | Register select for the write |
| sw_wr_data | input | 32 | Write data |
| cur_link | output | 32 | Current link register |
| cur_count | output | 16 | Remaining byte count |
| cur_src | output | 32 | Source address register |
| cur_dst | output | 32 | Destination address register |
| cur_cfg | output | 32 | Configuration register |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Byte address of requested word |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 32 | Read response data |
| rd_err | input | 1 | Read response error, valid with rd_ack |
| seg_start | output | 1 | One-cycle launch of a loaded segment |
| seg_done | input | 1 | Transfer engine finished the segment |
| seg_xfer_vld | input | 1 | Engine moved bytes this cycle |
| seg_xfer_bytes | input | 16 | Bytes moved this cycle |
| tc_event | output | 1 | Whole chain complete pulse |
| err_event | output | 1 | Descriptor fetch error pulse |
| busy | output | 1 | Channel active |

## Verification
On every cycle, the assertions check several local rules. The read address holds steady while a request waits, and it advances by one word after each good response. Each launch is a single-cycle pulse. The count never exceeds its cap. A locked channel ignores software writes. A completion or an error leaves the enable bit clear and the channel stopped. A completion also requires a link without the chaining flag. The bench scenarios show what no single-cycle rule can. These are the full order of fetch addresses across a three-segment chain and the mapping of each descriptor word into the registers. They also cover the absence of a completion pulse between segments, saturating residue arithmetic, and recovery after a faulted fetch.

// File: rtl/desc_seq_pkg.sv
package desc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LAUNCH,
    ST_RUN,
    ST_NEXT,
    ST_DONE,
    ST_FAULT,
    ST_HALT
  } seq_state_e;

  localparam logic [2:0] SEL_LINK  = 3'd0;
  localparam logic [2:0] SEL_COUNT = 3'd1;
  localparam logic [2:0] SEL_SRC   = 3'd2;
  localparam logic [2:0] SEL_DST   = 3'd3;
  localparam logic [2:0] SEL_CFG   = 3'd4;

  localparam int unsigned WORD_LINK  = 0;
  localparam int unsigned WORD_COUNT = 4;
  localparam int unsigned WORD_SRC   = 5;
  localparam int unsigned WORD_DST   = 6;
  localparam int unsigned WORD_CFG   = 7;

  localparam int unsigned CHAIN_BIT  = 1;
  localparam int unsigned ENABLE_BIT = 0;

endpackage

// File: rtl/desc_seq_ctrl.sv
module desc_seq_ctrl
  import desc_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DESC_WORDS = 8,
  localparam int unsigned IDX_W     = $clog2(DESC_WORDS),
  localparam int unsigned ALIGN_W   = $clog2(DESC_WORDS * 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic              seg_done,
  input  logic              rd_ack,
  input  logic              rd_err,
  input  logic [ADDR_W-1:0] link_in,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              ld_vld,
  output logic [IDX_W-1:0]  ld_idx,
  output logic              seg_start,
  output logic              running,
  output logic              tc_event,
  output logic              err_event,
  output logic              busy,
  output logic              sw_allow,
  output logic              end_clear
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              base_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    base_d  = base_q;
    base_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cfg_wr && cfg_en) state_d = ST_LAUNCH;
      end
      ST_HALT: begin
        if (cfg_wr) state_d = cfg_en ? ST_LAUNCH : ST_IDLE;
      end
      ST_LAUNCH: state_d = ST_RUN;
      ST_RUN: begin
        if (seg_done) state_d = ST_NEXT;
      end
      ST_NEXT: begin
        if (link_in[CHAIN_BIT]) begin
          state_d = ST_FETCH;
          base_d  = {link_in[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
          base_en = 1'b1;
          idx_d   = '0;
          idx_en  = 1'b1;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_FETCH: begin
        if (rd_ack) begin
          if (rd_err) begin
            state_d = ST_FAULT;
          end else if (idx_q == LAST_IDX) begin
            state_d = ST_LAUNCH;
          end else begin
            idx_d  = idx_q + 1'b1;
            idx_en = 1'b1;
          end
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_HALT;
      default:  state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en)  idx_q  <= idx_d;
      if (base_en) base_q <= base_d;
    end
  end

  // outputs
  always_comb begin
    rd_req    = (state_q == ST_FETCH);
    rd_addr   = base_q | (ADDR_W'(idx_q) << 2);
    ld_vld    = (state_q == ST_FETCH) && rd_ack && !rd_err;
    ld_idx    = idx_q;
    seg_start = (state_q == ST_LAUNCH);
    running   = (state_q == ST_RUN);
    tc_event  = (state_q == ST_DONE);
    err_event = (state_q == ST_FAULT);
    sw_allow  = (state_q == ST_IDLE) || (state_q == ST_HALT);
    busy      = !sw_allow;
    end_clear = (state_q == ST_DONE) || (state_q == ST_FAULT);
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R5

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack && !rd_err && idx_q != LAST_IDX) |=> (rd_addr == $past(rd_addr) + ADDR_W'(4))); // R5

  AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_start |=> !seg_start); // R3

  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> (!busy && !seg_start && !tc_event)); // R10

endmodule

// File: rtl/desc_seq_regs.sv
module desc_seq_regs
  import desc_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MAX_SEG = 32'h1ffc,
  parameter int unsigned IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_en,
  input  logic [2:0]        sw_wr_sel,
  input  logic [ADDR_W-1:0] sw_wr_data,
  input  logic              sw_allow,
  input  logic              ld_vld,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [ADDR_W-1:0] ld_data,
  input  logic              xfer_vld,
  input  logic [CNT_W-1:0]  xfer_bytes,
  input  logic              end_clear,
  output logic [ADDR_W-1:0] link_q,
  output logic [CNT_W-1:0]  count_q,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [ADDR_W-1:0] cfg_q
);

  localparam int unsigned N_PLAIN = 3;

  function automatic logic [2:0] plain_sel(input int unsigned g);
    case (g)
      0:       return SEL_LINK;
      1:       return SEL_SRC;
      default: return SEL_DST;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] plain_word(input int unsigned g);
    case (g)
      0:       return IDX_W'(WORD_LINK);
      1:       return IDX_W'(WORD_SRC);
      default: return IDX_W'(WORD_DST);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [ADDR_W-1:0] v);
    if (v > ADDR_W'(MAX_SEG)) return CNT_W'(MAX_SEG);
    else                      return v[CNT_W-1:0];
  endfunction

  logic sw_ok;
  assign sw_ok = sw_wr_en && sw_allow;

  // link, source and destination share one structure
  logic [ADDR_W-1:0] plain_q [N_PLAIN];

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    logic              en;
    logic [ADDR_W-1:0] d;
    always_comb begin
      en = (sw_ok && sw_wr_sel == plain_sel(g)) ||
           (ld_vld && ld_idx == plain_word(g));
      d  = ld_vld ? ld_data : sw_wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  plain_q[g] <= '0;
      else if (en) plain_q[g] <= d;
    end
  end

  assign link_q = plain_q[0];
  assign src_q  = plain_q[1];
  assign dst_q  = plain_q[2];

  // count: capped on load, saturating decrement while running
  logic             count_en;
  logic [CNT_W-1:0] count_d;
  always_comb begin
    count_en = 1'b0;
    count_d  = count_q;
    if (xfer_vld) begin
      count_en = 1'b1;
      count_d  = (xfer_bytes >= count_q) ? '0 : (count_q - xfer_bytes);
    end else if (ld_vld && ld_idx == IDX_W'(WORD_COUNT)) begin
      count_en = 1'b1;
      count_d  = clamp_cnt(ld_data);
    end else if (sw_ok && sw_wr_sel == SEL_COUNT) begin
      count_en = 1'b1;
      count_d  = clamp_cnt(sw_wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  // configuration: enable bit dropped at chain end or fault
  logic              cfg_en_w;
  logic [ADDR_W-1:0] cfg_d;
  always_comb begin
    cfg_en_w = 1'b0;
    cfg_d    = cfg_q;
    if (end_clear) begin
      cfg_en_w = 1'b1;
      cfg_d    = cfg_q & ~(ADDR_W'(1) << ENABLE_BIT);
    end else if (ld_vld && ld_idx == IDX_W'(WORD_CFG)) begin
      cfg_en_w = 1'b1;
      cfg_d    = ld_data;
    end else if (sw_ok && sw_wr_sel == SEL_CFG) begin
      cfg_en_w = 1'b1;
      cfg_d    = sw_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (cfg_en_w) cfg_q <= cfg_d;
  end

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(MAX_SEG)); // R8

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && !sw_allow && !ld_vld && !xfer_vld && !end_clear)
      |=> $stable({link_q, src_q, dst_q, cfg_q, count_q})); // R4

  AST_END_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    end_clear |=> !cfg_q[ENABLE_BIT]); // R7

endmodule

// File: rtl/desc_seq.sv
module desc_seq
  import desc_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned MAX_SEG    = 32'h1ffc,
  parameter int unsigned DESC_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_en,
  input  logic [2:0]        sw_wr_sel,
  input  logic [ADDR_W-1:0] sw_wr_data,
  output logic [ADDR_W-1:0] cur_link,
  output logic [CNT_W-1:0]  cur_count,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [ADDR_W-1:0] cur_cfg,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [ADDR_W-1:0] rd_data,
  input  logic              rd_err,
  output logic              seg_start,
  input  logic              seg_done,
  input  logic              seg_xfer_vld,
  input  logic [CNT_W-1:0]  seg_xfer_bytes,
  output logic              tc_event,
  output logic              err_event,
  output logic              busy
);

  localparam int unsigned IDX_W = $clog2(DESC_WORDS);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic             cfg_wr, sw_allow, ld_vld, running, end_clear;
  logic [IDX_W-1:0] ld_idx;

  assign cfg_wr = sw_wr_en && sw_allow && (sw_wr_sel == SEL_CFG);

  desc_seq_ctrl #(
    .ADDR_W     (ADDR_W),
    .DESC_WORDS (DESC_WORDS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_wr    (cfg_wr),
    .cfg_en    (sw_wr_data[ENABLE_BIT]),
    .seg_done  (seg_done),
    .rd_ack    (rd_ack),
    .rd_err    (rd_err),
    .link_in   (cur_link),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .ld_vld    (ld_vld),
    .ld_idx    (ld_idx),
    .seg_start (seg_start),
    .running   (running),
    .tc_event  (tc_event),
    .err_event (err_event),
    .busy      (busy),
    .sw_allow  (sw_allow),
    .end_clear (end_clear)
  );

  desc_seq_regs #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .MAX_SEG (MAX_SEG),
    .IDX_W   (IDX_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_sel  (sw_wr_sel),
    .sw_wr_data (sw_wr_data),
    .sw_allow   (sw_allow),
    .ld_vld     (ld_vld),
    .ld_idx     (ld_idx),
    .ld_data    (rd_data),
    .xfer_vld   (seg_xfer_vld && running),
    .xfer_bytes (seg_xfer_bytes),
    .end_clear  (end_clear),
    .link_q     (cur_link),
    .count_q    (cur_count),
    .src_q      (cur_src),
    .dst_q      (cur_dst),
    .cfg_q      (cur_cfg)
  );

  AST_TC_NO_CHAIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tc_event |-> !cur_link[CHAIN_BIT]); // R7

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_req |-> (rd_addr[1:0] == 2'b00)); // R5

endmodule

// File: tb/desc_seq_tb.sv
module desc_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_wr_en;
  logic [2:0]  sw_wr_sel;
  logic [31:0] sw_wr_data;
  logic [31:0] cur_link, cur_src, cur_dst, cur_cfg;
  logic [15:0] cur_count;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack;
  logic [31:0] rd_data;
  logic        rd_err;
  logic        seg_start, seg_done, seg_xfer_vld;
  logic [15:0] seg_xfer_bytes;
  logic        tc_event, err_event, busy;

  always #2.5 clk = ~clk;

  desc_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data),
    .cur_link(cur_link), .cur_count(cur_count), .cur_src(cur_src),
    .cur_dst(cur_dst), .cur_cfg(cur_cfg),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_err(rd_err),
    .seg_start(seg_start), .seg_done(seg_done), .seg_xfer_vld(seg_xfer_vld),
    .seg_xfer_bytes(seg_xfer_bytes),
    .tc_event(tc_event), .err_event(err_event), .busy(busy)
  );

  int checks = 0;
  int failures = 0;
  int start_cnt = 0;
  int tc_cnt = 0;
  int err_cnt = 0;
  int fcnt = 0;
  logic [31:0] flog [0:31];
  logic [31:0] mem [0:63];
  logic        err_armed = 1'b0;
  logic [31:0] err_addr = 32'h0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // event monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (seg_start) start_cnt++;
      if (tc_event)  tc_cnt++;
      if (err_event) err_cnt++;
    end
  end

  // behavioural descriptor memory: one response every other cycle
  always @(negedge clk) begin
    if (rd_req && !rd_ack) begin
      rd_ack  <= 1'b1;
      rd_data <= mem[rd_addr[7:2]];
      rd_err  <= err_armed && (rd_addr == err_addr);
      if (fcnt < 32) flog[fcnt] <= rd_addr;
      fcnt++;
    end else begin
      rd_ack <= 1'b0;
      rd_err <= 1'b0;
    end
  end

  task automatic sw_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    sw_wr_en = 1'b1; sw_wr_sel = sel; sw_wr_data = data;
    @(negedge clk);
    sw_wr_en = 1'b0;
  endtask

  task automatic pulse_done();
    seg_done = 1'b1;
    @(negedge clk);
    seg_done = 1'b0;
  endtask

  task automatic pulse_xfer(input logic [15:0] bytes);
    seg_xfer_vld = 1'b1; seg_xfer_bytes = bytes;
    @(negedge clk);
    seg_xfer_vld = 1'b0;
  endtask

  function automatic int cnt_of(input int kind);
    case (kind)
      0:       return start_cnt;
      1:       return tc_cnt;
      default: return err_cnt;
    endcase
  endfunction

  task automatic wait_for(input int kind, input int target, input string req);
    int n = 0;
    while (cnt_of(kind) < target && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(req, 32'(cnt_of(kind) >= target), 32'd1);
  endtask

  task automatic put_desc(input int base, input logic [31:0] link, input logic [31:0] cnt,
                          input logic [31:0] src, input logic [31:0] dst, input logic [31:0] cfg);
    mem[base/4 + 0] = link;
    for (int i = 1; i < 4; i++) mem[base/4 + i] = 32'hBAD0_0000 + 32'(i);
    mem[base/4 + 4] = cnt;
    mem[base/4 + 5] = src;
    mem[base/4 + 6] = dst;
    mem[base/4 + 7] = cfg;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    sw_wr_en = 1'b0; sw_wr_sel = '0; sw_wr_data = '0;
    seg_done = 1'b0; seg_xfer_vld = 1'b0; seg_xfer_bytes = '0;
    rd_ack = 1'b0; rd_data = '0; rd_err = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 32'(busy), 32'd0);
    check("R1 rd_req in reset", 32'(rd_req), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 outputs idle", {27'd0, busy, rd_req, seg_start, tc_event, err_event}, 32'd0);
    check("R1 regs zero", cur_link | cur_src | cur_dst | cur_cfg | 32'(cur_count), 32'd0);
  endtask

  task automatic t_regs();
    sw_write(3'd0, 32'h0000_1230);
    sw_write(3'd1, 32'h0000_0100);
    sw_write(3'd2, 32'hA000_0004);
    sw_write(3'd3, 32'hB000_0008);
    sw_write(3'd4, 32'h0000_00F0);
    check("R2 link", cur_link, 32'h0000_1230);
    check("R2 count", 32'(cur_count), 32'h100);
    check("R2 src", cur_src, 32'hA000_0004);
    check("R2 dst", cur_dst, 32'hB000_0008);
    check("R2 cfg", cur_cfg, 32'h0000_00F0);
    check("R3 no start without enable", 32'(busy), 32'd0);
    sw_write(3'd1, 32'h0000_3000);
    check("R8 sw count capped", 32'(cur_count), 32'h1ffc);
  endtask

  task automatic t_single();
    int s0 = start_cnt;
    int t0 = tc_cnt;
    sw_write(3'd0, 32'h0);
    sw_write(3'd1, 32'h100);
    sw_write(3'd2, 32'h111);
    sw_write(3'd3, 32'h222);
    sw_write(3'd4, 32'h3);
    check("R3 busy after enable", 32'(busy), 32'd1);
    wait_for(0, s0 + 1, "R3 launch seen");
    @(negedge clk);
    check("R3 single launch", 32'(start_cnt - s0), 32'd1);
    pulse_xfer(16'h40);
    check("R9 count decremented", 32'(cur_count), 32'hC0);
    check("R9 link readable", cur_link, 32'h0);
    sw_write(3'd2, 32'h999);
    check("R4 src unchanged while busy", cur_src, 32'h111);
    sw_write(3'd4, 32'h0);
    check("R4 cfg unchanged while busy", cur_cfg, 32'h3);
    pulse_xfer(16'h200);
    check("R9 count saturates", 32'(cur_count), 32'h0);
    pulse_done();
    wait_for(1, t0 + 1, "R7 tc seen");
    @(negedge clk);
    check("R7 busy low", 32'(busy), 32'd0);
    check("R7 enable cleared", cur_cfg, 32'h2);
    check("R7 one tc", 32'(tc_cnt - t0), 32'd1);
    check("R7 no fetch for zero link", 32'(fcnt), 32'd0);
  endtask

  task automatic t_chain();
    int s0 = start_cnt;
    int t0 = tc_cnt;
    int f0 = fcnt;
    put_desc(32'h40, 32'h0000_0082, 32'h20, 32'h1100, 32'h2100, 32'h51);
    put_desc(32'h80, 32'h0000_00C0, 32'h5000, 32'h1200, 32'h2200, 32'h71);
    sw_write(3'd0, 32'h0000_0043);
    sw_write(3'd1, 32'h10);
    sw_write(3'd2, 32'h1000);
    sw_write(3'd3, 32'h2000);
    sw_write(3'd4, 32'h31);
    wait_for(0, s0 + 1, "R3 chain first launch");
    @(negedge clk);
    pulse_done();
    wait_for(0, s0 + 2, "R6 second launch");
    check("R6 link from word0", cur_link, 32'h82);
    check("R6 count from word4", 32'(cur_count), 32'h20);
    check("R6 src from word5", cur_src, 32'h1100);
    check("R6 dst from word6", cur_dst, 32'h2100);
    check("R6 cfg from word7", cur_cfg, 32'h51);
    check("R7 no tc mid chain", 32'(tc_cnt - t0), 32'd0);
    for (int i = 0; i < 8; i++) check("R5 fetch order first", flog[f0 + i], 32'h40 + 32'(4 * i));
    @(negedge clk);
    pulse_done();
    wait_for(0, s0 + 3, "R6 third launch");
    check("R8 fetched count capped", 32'(cur_count), 32'h1ffc);
    check("R6 third src", cur_src, 32'h1200);
    for (int i = 0; i < 8; i++) check("R5 fetch order second", flog[f0 + 8 + i], 32'h80 + 32'(4 * i));
    @(negedge clk);
    pulse_done();
    wait_for(1, t0 + 1, "R7 chain tc");
    @(negedge clk);
    check("R7 one tc for chain", 32'(tc_cnt - t0), 32'd1);
    check("R7 unflagged link not fetched", 32'(fcnt - f0), 32'd16);
    check("R7 chain enable cleared", cur_cfg, 32'h70);
    check("R7 chain busy low", 32'(busy), 32'd0);
    check("R3 three launches", 32'(start_cnt - s0), 32'd3);
  endtask

  task automatic t_fault();
    int s0 = start_cnt;
    int t0 = tc_cnt;
    int e0 = err_cnt;
    put_desc(32'hA0, 32'h0, 32'h30, 32'h1300, 32'h2300, 32'h91);
    err_armed = 1'b1; err_addr = 32'hA8;
    sw_write(3'd0, 32'h0000_00A2);
    sw_write(3'd1, 32'h8);
    sw_write(3'd4, 32'h1);
    wait_for(0, s0 + 1, "R10 initial launch");
    @(negedge clk);
    pulse_done();
    wait_for(2, e0 + 1, "R10 error seen");
    @(negedge clk);
    check("R10 busy low after error", 32'(busy), 32'd0);
    check("R10 enable cleared", cur_cfg, 32'h0);
    check("R10 no launch after error", 32'(start_cnt - s0), 32'd1);
    check("R10 no tc after error", 32'(tc_cnt - t0), 32'd0);
    check("R10 single error pulse", 32'(err_cnt - e0), 32'd1);
    err_armed = 1'b0;
    sw_write(3'd4, 32'h5);
    wait_for(0, s0 + 2, "R10 restart launch");
    check("R10 restart cfg", cur_cfg, 32'h5);
    @(negedge clk);
    pulse_done();
    wait_for(1, t0 + 1, "R10 restart completes");
  endtask

  initial begin
    t_reset();
    t_regs();
    t_single();
    t_chain();
    t_fault();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule